// File: doc/BRIEF.md
# Two-Channel Edge/Level External Interrupt Controller

This block watches a set of external interrupt pins (two by default) and turns their activity into interrupt requests for a processor. Each channel has a 2-bit sense selection:
- low level
- any change
- falling edge
- rising edge

Each channel also has a mask bit. A single global enable input gates every channel. Edge-sensed events are held in sticky pending flags. Software can read these flags and clear them through a small byte-wide register port, and the interrupt logic can also clear one by acknowledging its request. A low-level request has no stored flag: it simply follows the pin. The pins are read through a synchronizer, whatever is driving them, so writing the pin's own output value is a way to force a request.

A second part runs on a slow, always-on clock. It wakes the system from a low-power state when an enabled low-level channel stays low. The level must be seen low on two consecutive slow-clock samples before a wake-up starts. A start-up period of a parameterized number of slow cycles then runs. At its end the pin is sampled again: a wake-up interrupt is signalled only if the level is still low, otherwise the part wakes with no interrupt.

The wake-up state machine has four states:
- WK_IDLE: no level seen.
- WK_SEEN1: one low sample taken.
- WK_STARTUP: counting the start-up period.
- WK_AWAKE: wake-up done, with the interrupt decision held.

Its transitions are:
- IDLE to SEEN1 on a low sample while asleep.
- SEEN1 back to IDLE when the next sample is high.
- SEEN1 to STARTUP on a second low sample.
- STARTUP to AWAKE when the count expires.
- Any state to IDLE when the sleep input drops.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the control, mask and pending registers read 0x00, and irq_o, wake_o and wake_irq_o are low.
- R2: The register map is: address 0 is control, address 1 is mask (bit i enables channel i), and address 2 is pending (bit i is channel i's flag). In the control register, channel i's sense field occupies bits 2i+1:2i, so channel 1 uses bits 3:2 and channel 0 uses bits 1:0. Control bits 7:4 and mask bits 7:2 read as zero, and writes to them are ignored.
- R3: The sense encoding is 00 low level, 01 any change, 10 falling edge and 11 rising edge. In an edge mode, a matching edge on the pin sets that channel's pending flag, and a non-matching edge does not.
- R4: In low-level mode, irq_o[i] is high while the pin is low and drops once it returns high, and no pending flag is set.
- R5: irq_o[i] is asserted only when gie_i and mask bit i are both set. A flag that is set while masked stays readable and raises irq_o[i] once the channel is enabled.
- R6: Writing 1 to pending bit i, or pulsing ack_i[i], clears the flag. Writing 0 leaves the flag unchanged.
- R7: A flag that is clear stays clear while the channel is in low-level mode, whatever edges the pin makes.
- R8: While sleep_i is high and a channel is enabled in low-level mode, wake_o rises only after the pin has been low on two consecutive slow_clk samples. A low lasting a single sample causes no wake-up.
- R9: STARTUP_CYC slow cycles after wake_o rises, wake_irq_o goes high if the enabled pin is still low. If the pin has gone high by then, wake_o stays high and wake_irq_o stays low.
- R10: Dropping sleep_i returns the wake-up logic to idle, so wake_o and wake_irq_o go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| slow_clk | input | 1 | Always-on slow clock for wake-up detection |
| pin_i | input | NCH | External interrupt pins |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| ack_i | input | NCH | Per-channel request acknowledge |
| irq_o | output | NCH | Per-channel interrupt request |
| sleep_i | input | 1 | Low-power state indicator |
| wake_o | output | 1 | Wake-up in progress or complete |
| wake_irq_o | output | 1 | Wake-up accompanied by a level interrupt |

## Verification
The hardest case to reach is a wake-up that must be told apart from a glitch. A level that is low for exactly one slow sample must not start a wake-up, while a level held for two samples must. After that, the outcome of the start-up period depends on whether the pin is still low in the last cycle of the count. The bench drives the pin only on the falling edges of slow_clk, so it knows exactly which slow samples see the low level. It then releases the pin partway through the start-up count to produce the wake-without-interrupt outcome.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_t;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_SEEN1,
        WK_STARTUP,
        WK_AWAKE
    } wake_st_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MASK = 2'd1;
    localparam logic [1:0] ADDR_PEND = 2'd2;
endpackage

// File: rtl/eirq_regs.sv
module eirq_regs
    import ext_irq_pkg::*;
#(
    parameter int NCH = 2,
    parameter int DW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [DW-1:0]     wdata_i,
    input  logic [NCH-1:0]    pend_i,
    output logic [2*NCH-1:0]  sense_o,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    pend_clr_o,
    output logic [DW-1:0]     rdata_o
);
    localparam int CW = 2 * NCH;

    logic [CW-1:0]  ctrl_q;
    logic [NCH-1:0] mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (wr_en_i) begin
            if (addr_i == ADDR_CTRL) ctrl_q <= wdata_i[CW-1:0];
            if (addr_i == ADDR_MASK) mask_q <= wdata_i[NCH-1:0];
        end
    end

    always_comb begin
        pend_clr_o = '0;
        if (wr_en_i && addr_i == ADDR_PEND) pend_clr_o = wdata_i[NCH-1:0];
    end

    always_comb begin
        unique case (addr_i)
            ADDR_CTRL: rdata_o = {{(DW-CW){1'b0}}, ctrl_q};
            ADDR_MASK: rdata_o = {{(DW-NCH){1'b0}}, mask_q};
            ADDR_PEND: rdata_o = {{(DW-NCH){1'b0}}, pend_i};
            default:   rdata_o = '0;
        endcase
    end

    assign sense_o = ctrl_q;
    assign mask_o  = mask_q;

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_CTRL) |=> $stable(ctrl_q));
    p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/eirq_chan.sv
module eirq_chan
    import ext_irq_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_i,
    input  sense_t sense_i,
    input  logic   en_i,
    input  logic   clr_i,
    output logic   pend_o,
    output logic   req_o
);
    logic [SYNC-1:0] sync_q;
    logic            prev_q;
    logic            flag_q;
    logic            pin_s;
    logic            rise;
    logic            fall;
    logic            hit;

    // Idle-high reset avoids a false edge when the pin rests high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], pin_i};
            prev_q <= sync_q[SYNC-1];
        end
    end

    assign pin_s = sync_q[SYNC-1];
    assign rise  = pin_s & ~prev_q;
    assign fall  = ~pin_s & prev_q;

    always_comb begin
        unique case (sense_i)
            SNS_LOW:  hit = 1'b0;
            SNS_ANY:  hit = rise | fall;
            SNS_FALL: hit = fall;
            SNS_RISE: hit = rise;
        endcase
    end

    // A new event takes priority over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (hit)    flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign pend_o = flag_q;
    assign req_o  = en_i & ((sense_i == SNS_LOW) ? ~pin_s : flag_q);

    p_lvl_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SNS_LOW && !flag_q) |=> !flag_q);
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_q);
    p_req_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> en_i);
endmodule

// File: rtl/eirq_wake.sv
module eirq_wake
    import ext_irq_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int STARTUP_CYC = 16
) (
    input  logic           sclk,
    input  logic           rst_n,
    input  logic           sleep_i,
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] qual_i,
    output logic           wake_o,
    output logic           wake_irq_o
);
    localparam int CNTW = $clog2(STARTUP_CYC + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(STARTUP_CYC - 1);

    wake_st_t       st_q, st_d;
    logic [NCH-1:0] samp_q;
    logic [CNTW-1:0] cnt_q;
    logic           irq_q;
    logic           low_hit;
    logic           cnt_done;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) samp_q <= '1;
        else        samp_q <= pin_i;
    end

    assign low_hit  = |(qual_i & ~samp_q);
    assign cnt_done = (cnt_q == LAST);

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) st_q <= WK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WK_IDLE:    if (low_hit) st_d = WK_SEEN1;
            WK_SEEN1:   st_d = low_hit ? WK_STARTUP : WK_IDLE;
            WK_STARTUP: if (cnt_done) st_d = WK_AWAKE;
            WK_AWAKE:   st_d = WK_AWAKE;
        endcase
        if (!sleep_i) st_d = WK_IDLE;
    end

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (st_q == WK_STARTUP && !cnt_done) cnt_q <= cnt_q + 1'b1;
            else if (st_q != WK_STARTUP)         cnt_q <= '0;
            if (st_d == WK_IDLE)                 irq_q <= 1'b0;
            else if (st_q == WK_STARTUP && cnt_done) irq_q <= low_hit;
        end
    end

    assign wake_o     = (st_q == WK_STARTUP) || (st_q == WK_AWAKE);
    assign wake_irq_o = irq_q && (st_q == WK_AWAKE);

    p_two_samples_r8: assert property (@(posedge sclk) disable iff (!rst_n)
        (st_q == WK_IDLE) |=> (st_q != WK_STARTUP));
    p_cnt_range_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        (st_q == WK_STARTUP) |-> (cnt_q < CNTW'(STARTUP_CYC)));
    p_irq_needs_wake_r9: assert property (@(posedge sclk) disable iff (!rst_n)
        wake_irq_o |-> wake_o);
    p_sleep_exit_r10: assert property (@(posedge sclk) disable iff (!rst_n)
        !sleep_i |=> (st_q == WK_IDLE));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int DW          = 8,
    parameter int SYNC        = 2,
    parameter int STARTUP_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slow_clk,
    input  logic [NCH-1:0] pin_i,
    input  logic           gie_i,
    input  logic           reg_wr_i,
    input  logic [1:0]     reg_addr_i,
    input  logic [DW-1:0]  reg_wdata_i,
    output logic [DW-1:0]  reg_rdata_o,
    input  logic [NCH-1:0] ack_i,
    output logic [NCH-1:0] irq_o,
    input  logic           sleep_i,
    output logic           wake_o,
    output logic           wake_irq_o
);
    logic [2*NCH-1:0] sense;
    logic [NCH-1:0]   mask;
    logic [NCH-1:0]   pend;
    logic [NCH-1:0]   pend_clr;
    logic [NCH-1:0]   lvl_qual;

    eirq_regs #(.NCH(NCH), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .pend_i     (pend),
        .sense_o    (sense),
        .mask_o     (mask),
        .pend_clr_o (pend_clr),
        .rdata_o    (reg_rdata_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        eirq_chan #(.SYNC(SYNC)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (pin_i[i]),
            .sense_i (sense_t'(sense[2*i +: 2])),
            .en_i    (gie_i & mask[i]),
            .clr_i   (pend_clr[i] | ack_i[i]),
            .pend_o  (pend[i]),
            .req_o   (irq_o[i])
        );
        assign lvl_qual[i] = gie_i & mask[i] & (sense[2*i +: 2] == SNS_LOW);
    end

    eirq_wake #(.NCH(NCH), .STARTUP_CYC(STARTUP_CYC)) u_wake (
        .sclk       (slow_clk),
        .rst_n      (rst_n),
        .sleep_i    (sleep_i),
        .pin_i      (pin_i),
        .qual_i     (lvl_qual),
        .wake_o     (wake_o),
        .wake_irq_o (wake_irq_o)
    );

    p_irq_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_o) |-> gie_i);
endmodule

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;
    localparam int NCH = 2;
    localparam int DW  = 8;
    localparam int SU  = 16;

    logic          clk = 0, slow_clk = 0, rst_n = 0;
    logic [NCH-1:0] pin = '1, ack = '0;
    logic          gie = 0, wr = 0, sleep = 0;
    logic [1:0]    addr = 0;
    logic [DW-1:0] wdata = 0, rdata;
    logic [NCH-1:0] irq;
    logic          wake, wake_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always #100 slow_clk = ~slow_clk;

    ext_irq_ctrl #(.NCH(NCH), .DW(DW), .SYNC(2), .STARTUP_CYC(SU)) u0 (
        .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .pin_i(pin), .gie_i(gie),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ack_i(ack), .irq_o(irq), .sleep_i(sleep), .wake_o(wake), .wake_irq_o(wake_irq)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sclks(int n);
        repeat (n) @(negedge slow_clk);
    endtask

    task automatic wreg(logic [1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic rreg(logic [1:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic setpin(int i, logic v);
        @(negedge clk);
        pin[i] = v;
        clks(4);
    endtask

    task automatic t_reset;
        int v;
        rreg(0, v); check("R1 ctrl", v, 0);
        rreg(1, v); check("R1 mask", v, 0);
        rreg(2, v); check("R1 pend", v, 0);
        check("R1 irq", int'(irq), 0);
        check("R1 wake", int'({wake, wake_irq}), 0);
    endtask

    task automatic t_regs;
        int v;
        wreg(0, 8'hFF); rreg(0, v); check("R2 ctrl reserved", v, 8'h0F);
        wreg(1, 8'hFF); rreg(1, v); check("R2 mask reserved", v, 8'h03);
        wreg(0, 8'hF6); rreg(0, v); check("R2 ctrl fields", v, 8'h06);
        wreg(0, 0); wreg(1, 0);
    endtask

    task automatic t_falling;
        int v;
        wreg(0, 8'h02); wreg(2, 8'hFF);
        setpin(0, 0);
        rreg(2, v); check("R3 falling sets flag", v, 1);
        check("R5 masked no irq", int'(irq), 0);
        wreg(2, 8'h01); rreg(2, v); check("R6 write1 clears", v, 0);
        setpin(0, 1);
        rreg(2, v); check("R3 rise ignored in fall mode", v, 0);
        setpin(0, 0);
        wreg(2, 8'h00); rreg(2, v); check("R6 write0 keeps", v, 1);
        gie = 1; wreg(1, 8'h01); clks(1);
        check("R5 pending raises irq", int'(irq), 1);
        @(negedge clk); ack = 2'b01; @(negedge clk); ack = 0;
        #1 check("R6 ack clears irq", int'(irq), 0);
        rreg(2, v); check("R6 ack clears flag", v, 0);
        setpin(0, 1);
        gie = 0; wreg(1, 0);
    endtask

    task automatic t_rising;
        int v;
        wreg(0, 8'h0C); wreg(2, 8'hFF);
        setpin(1, 0);
        rreg(2, v); check("R3 fall ignored in rise mode", v, 0);
        setpin(1, 1);
        rreg(2, v); check("R3 rising sets ch1", v, 2);
        wreg(0, 8'h04); wreg(2, 8'hFF);
        setpin(1, 0);
        rreg(2, v); check("R3 any change fall", v, 2);
        wreg(2, 8'h02);
        setpin(1, 1);
        rreg(2, v); check("R3 any change rise", v, 2);
        wreg(2, 8'hFF); wreg(0, 0);
    endtask

    task automatic t_level;
        int v;
        wreg(0, 0); wreg(1, 8'h01); gie = 1;
        setpin(0, 0);
        check("R4 low raises irq", int'(irq), 1);
        rreg(2, v); check("R7 no flag in level mode", v, 0);
        setpin(0, 1);
        check("R4 high drops irq", int'(irq), 0);
        rreg(2, v); check("R7 still no flag after edge", v, 0);
        gie = 0;
        setpin(0, 0);
        check("R5 gie off blocks", int'(irq), 0);
        setpin(0, 1);
    endtask

    task automatic t_wake;
        gie = 1; wreg(0, 0); wreg(1, 8'h01);
        sleep = 1;
        sclks(1);
        pin[0] = 0; sclks(1); pin[0] = 1;
        sclks(4);
        check("R8 single sample no wake", int'(wake), 0);
        pin[0] = 0;
        sclks(1);
        check("R8 one sample not yet", int'(wake), 0);
        sclks(2);
        check("R8 two samples wake", int'(wake), 1);
        check("R9 no irq during startup", int'(wake_irq), 0);
        sclks(SU + 2);
        check("R9 level held gives irq", int'({wake, wake_irq}), 3);
        sleep = 0; sclks(2);
        check("R10 sleep exit idles", int'({wake, wake_irq}), 0);
        pin[0] = 1; sclks(2);
        sleep = 1;
        pin[0] = 0; sclks(3);
        check("R8 second wake", int'(wake), 1);
        pin[0] = 1;
        sclks(SU + 2);
        check("R9 level gone wake only", int'({wake, wake_irq}), 2);
        sleep = 0; sclks(2);
        check("R10 idle again", int'(wake), 0);
        gie = 0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #100000;
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        clks(3); rst_n = 1; clks(2);
        t_reset();
        t_regs();
        t_falling();
        t_rising();
        t_level();
        t_wake();
        finish_run();
    end
endmodule